// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a processor's execute stage. At each instruction boundary it chooses at most one pending event: a software request, a non-maskable request, a single-step trap, or a maskable device request. Once it has chosen, it writes the processor's state to the stack, reads the handler's segment and pointer from a vector table in low memory, and hands the new processor state back as a one-cycle load pulse. A return strobe runs the reverse sequence. It pops the saved words and hands them back the same way.

All memory traffic uses one word-wide port that holds each request until the memory acknowledges it. Stack addresses are the stack pointer value itself. Vector n occupies byte addresses 4n (pointer word) and 4n+2 (segment word). A maskable request is acknowledged for exactly one cycle, and the requesting device places its vector number on the vector bus during that cycle.

Top module: `intr_seq`

## Requirements
- R1: After reset, `busy`, `dev_ack`, `load` and `mem_req` are all 0.
- R2: An event is accepted only in a cycle where `boundary` is 1 and the block is idle. Requests presented without `boundary` start nothing.
- R3: A maskable request is accepted only while flag bit 9 (interrupt enable) is 1. When it is accepted, `dev_ack` is 1 for exactly one cycle, and the vector is the value of `vec_bus` in that cycle.
- R4: A non-maskable request uses vector 2 and is accepted whatever the value of flag bit 9.
- R5: While flag bit 8 (step) is 1, every boundary raises a trap with vector 1.
- R6: When several events are pending at one boundary, the order is: software request, then non-maskable request, then step trap, then maskable request.
- R7: `sw_req` uses vector `sw_vec`. `ovf_req` uses vector 4 only when flag bit 11 (overflow) is 1. Otherwise it has no effect.
- R8: Entry makes exactly three writes, in this order: flags to sp-2, code segment to sp-4, pointer to sp-6.
- R9: After entry, `load` delivers `new_ip` = word at 4n, `new_cs` = word at 4n+2, `new_sp` = sp-6, and `new_flags` = the saved flags with bits 9 and 8 cleared.
- R10: On return, the block reads the pointer from sp, the segment from sp+2 and the flags from sp+4, and makes no writes. `load` then delivers these words and `new_sp` = sp+6.
- R11: `busy` is 1 from the cycle after acceptance until the `load` cycle, in which it is 0. Boundary strobes that arrive while `busy` is 1 are ignored.
- R12: While `mem_req` is 1 and `mem_ack` is 0, the address, write enable and write data stay stable.
- R13: `ret_req` is accepted when idle and takes precedence over a boundary in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Current instruction has completed |
| ret_req | input | 1 | Return-from-handler strobe |
| mask_req | input | 1 | Maskable device request |
| hard_req | input | 1 | Non-maskable request |
| sw_req | input | 1 | Software interrupt with its own vector |
| sw_vec | input | VW | Vector number for `sw_req` |
| ovf_req | input | 1 | Overflow-conditional request |
| flags_in | input | W | Current flags word |
| cs_in | input | W | Current code segment |
| ip_in | input | W | Current instruction pointer |
| sp_in | input | W | Current stack pointer |
| dev_ack | output | 1 | Acknowledge to the requesting device |
| vec_bus | input | VW | Vector from the device during `dev_ack` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |
| busy | output | 1 | Sequence in progress |
| load | output | 1 | New state valid for one cycle |
| new_flags | output | W | Flags to load |
| new_cs | output | W | Code segment to load |
| new_ip | output | W | Instruction pointer to load |
| new_sp | output | W | Stack pointer to load |

## Verification
Directed cases put each event alone at a boundary, so that vectors 1, 2, 4, a software vector and a device vector can each be told apart by the handler address loaded. They also include the two gated cases, maskable with interrupts disabled and overflow with the flag clear, which must leave the block idle. Combined cases present several events at once to show the priority order. Another case presents a return and a boundary in the same cycle, where only reads may occur. Random rounds draw flags, segment, pointer, stack pointer and requests, and hold off the memory acknowledge for a random number of cycles. They also fire extra boundaries while the block is busy. Each round then checks the order and contents of the pushes, the loaded state, and a full round trip through the return.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ACK, S_PSH_F, S_PSH_CS, S_PSH_IP,
    S_VEC_IP, S_VEC_CS, S_POP_IP, S_POP_CS, S_POP_F, S_LOAD
  } seq_state_t;

  typedef enum logic [2:0] {EV_NONE, EV_SOFT, EV_HARD, EV_STEP, EV_MASK} ev_kind_t;

  localparam int FL_STEP = 8;
  localparam int FL_IEN  = 9;
  localparam int FL_OVF  = 11;

  localparam int VEC_STEP = 1;
  localparam int VEC_HARD = 2;
  localparam int VEC_OVF  = 4;
endpackage

// File: rtl/intr_pick.sv
module intr_pick
  import intr_seq_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic          boundary,
  input  logic          sw_req,
  input  logic [VW-1:0] sw_vec,
  input  logic          ovf_req,
  input  logic          hard_req,
  input  logic          mask_req,
  input  logic          fl_step,
  input  logic          fl_ien,
  input  logic          fl_ovf,
  output ev_kind_t      kind,
  output logic [VW-1:0] vec
);
  always_comb begin
    kind = EV_NONE;
    vec  = '0;
    if (boundary) begin
      if (sw_req) begin
        kind = EV_SOFT;
        vec  = sw_vec;
      end else if (ovf_req && fl_ovf) begin
        kind = EV_SOFT;
        vec  = VW'(VEC_OVF);
      end else if (hard_req) begin
        kind = EV_HARD;
        vec  = VW'(VEC_HARD);
      end else if (fl_step) begin
        kind = EV_STEP;
        vec  = VW'(VEC_STEP);
      end else if (mask_req && fl_ien) begin
        kind = EV_MASK;
      end
    end
  end
endmodule

// File: rtl/intr_mem_port.sv
module intr_mem_port #(
  parameter int W  = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          mem_ack,
  input  logic [W-1:0]  mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          done,
  output logic [W-1:0]  rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      if (mem_req) begin
        if (mem_ack) begin
          mem_req <= 1'b0;
          done    <= 1'b1;
          rdata   <= mem_rdata;
        end
      end else if (start) begin
        mem_req   <= 1'b1;
        mem_we    <= we;
        mem_addr  <= addr;
        mem_wdata <= wdata;
      end
    end
  end
endmodule

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
  import intr_seq_pkg::*;
#(
  parameter int W  = 16,
  parameter int VW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ev_kind_t      kind,
  input  logic [VW-1:0] pick_vec,
  input  logic          ret_req,
  input  logic [W-1:0]  flags_in,
  input  logic [W-1:0]  cs_in,
  input  logic [W-1:0]  ip_in,
  input  logic [W-1:0]  sp_in,
  input  logic [VW-1:0] vec_bus,
  input  logic          done,
  input  logic [W-1:0]  rdata,
  output logic          start,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [W-1:0]  wdata,
  output logic          dev_ack,
  output logic          busy,
  output logic          load,
  output logic [W-1:0]  new_flags,
  output logic [W-1:0]  new_cs,
  output logic [W-1:0]  new_ip,
  output logic [W-1:0]  new_sp
);
  localparam int BYTES = W / 8;
  localparam logic [W-1:0] OFF1 = W'(BYTES);
  localparam logic [W-1:0] OFF2 = W'(2 * BYTES);
  localparam logic [W-1:0] OFF3 = W'(3 * BYTES);
  localparam logic [W-1:0] CLR_MASK = (W'(1) << FL_IEN) | (W'(1) << FL_STEP);

  seq_state_t    state;
  logic          issued, is_ret, is_mem;
  logic [W-1:0]  sv_flags, sv_cs, sv_ip, sp_q, nip, ncs, nfl;
  logic [VW-1:0] vec_q;
  logic [AW-1:0] ent_addr;

  assign ent_addr = AW'(vec_q) * AW'(2 * BYTES);
  assign is_mem = (state inside {S_PSH_F, S_PSH_CS, S_PSH_IP, S_VEC_IP,
                                 S_VEC_CS, S_POP_IP, S_POP_CS, S_POP_F});
  assign start  = is_mem && !issued;

  always_comb begin
    we    = 1'b0;
    addr  = '0;
    wdata = '0;
    case (state)
      S_PSH_F:  begin we = 1'b1; addr = AW'(sp_q - OFF1); wdata = sv_flags; end
      S_PSH_CS: begin we = 1'b1; addr = AW'(sp_q - OFF2); wdata = sv_cs;    end
      S_PSH_IP: begin we = 1'b1; addr = AW'(sp_q - OFF3); wdata = sv_ip;    end
      S_VEC_IP: addr = ent_addr;
      S_VEC_CS: addr = ent_addr + AW'(BYTES);
      S_POP_IP: addr = AW'(sp_q);
      S_POP_CS: addr = AW'(sp_q + OFF1);
      S_POP_F:  addr = AW'(sp_q + OFF2);
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      issued    <= 1'b0;
      is_ret    <= 1'b0;
      busy      <= 1'b0;
      dev_ack   <= 1'b0;
      load      <= 1'b0;
      sv_flags  <= '0;
      sv_cs     <= '0;
      sv_ip     <= '0;
      sp_q      <= '0;
      vec_q     <= '0;
      nip       <= '0;
      ncs       <= '0;
      nfl       <= '0;
      new_flags <= '0;
      new_cs    <= '0;
      new_ip    <= '0;
      new_sp    <= '0;
    end else begin
      load <= 1'b0;
      if (is_mem) begin
        if (done) issued <= 1'b0;
        else if (start) issued <= 1'b1;
      end
      case (state)
        S_IDLE: begin
          if (ret_req) begin
            is_ret <= 1'b1;
            sp_q   <= sp_in;
            busy   <= 1'b1;
            state  <= S_POP_IP;
          end else if (kind != EV_NONE) begin
            is_ret   <= 1'b0;
            sv_flags <= flags_in;
            sv_cs    <= cs_in;
            sv_ip    <= ip_in;
            sp_q     <= sp_in;
            vec_q    <= pick_vec;
            busy     <= 1'b1;
            if (kind == EV_MASK) begin
              dev_ack <= 1'b1;
              state   <= S_ACK;
            end else begin
              state <= S_PSH_F;
            end
          end
        end
        S_ACK: begin
          dev_ack <= 1'b0;
          vec_q   <= vec_bus;
          state   <= S_PSH_F;
        end
        S_PSH_F:  if (done) state <= S_PSH_CS;
        S_PSH_CS: if (done) state <= S_PSH_IP;
        S_PSH_IP: if (done) state <= S_VEC_IP;
        S_VEC_IP: if (done) begin nip <= rdata; state <= S_VEC_CS; end
        S_VEC_CS: if (done) begin
          ncs   <= rdata;
          nfl   <= sv_flags & ~CLR_MASK;
          state <= S_LOAD;
        end
        S_POP_IP: if (done) begin nip <= rdata; state <= S_POP_CS; end
        S_POP_CS: if (done) begin ncs <= rdata; state <= S_POP_F; end
        S_POP_F:  if (done) begin nfl <= rdata; state <= S_LOAD; end
        S_LOAD: begin
          new_ip    <= nip;
          new_cs    <= ncs;
          new_flags <= nfl;
          new_sp    <= is_ret ? (sp_q + OFF3) : (sp_q - OFF3);
          load      <= 1'b1;
          busy      <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_seq_pkg::*;
#(
  parameter int W  = 16,
  parameter int VW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boundary,
  input  logic          ret_req,
  input  logic          mask_req,
  input  logic          hard_req,
  input  logic          sw_req,
  input  logic [VW-1:0] sw_vec,
  input  logic          ovf_req,
  input  logic [W-1:0]  flags_in,
  input  logic [W-1:0]  cs_in,
  input  logic [W-1:0]  ip_in,
  input  logic [W-1:0]  sp_in,
  output logic          dev_ack,
  input  logic [VW-1:0] vec_bus,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  input  logic          mem_ack,
  output logic          busy,
  output logic          load,
  output logic [W-1:0]  new_flags,
  output logic [W-1:0]  new_cs,
  output logic [W-1:0]  new_ip,
  output logic [W-1:0]  new_sp
);
  ev_kind_t      kind;
  logic [VW-1:0] pick_vec;
  logic          start, we, done;
  logic [AW-1:0] addr;
  logic [W-1:0]  wdata, rdata;

  intr_pick #(.VW(VW)) u_pick (
    .boundary (boundary),
    .sw_req   (sw_req),
    .sw_vec   (sw_vec),
    .ovf_req  (ovf_req),
    .hard_req (hard_req),
    .mask_req (mask_req),
    .fl_step  (flags_in[FL_STEP]),
    .fl_ien   (flags_in[FL_IEN]),
    .fl_ovf   (flags_in[FL_OVF]),
    .kind     (kind),
    .vec      (pick_vec)
  );

  intr_seq_ctrl #(.W(W), .VW(VW), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .pick_vec  (pick_vec),
    .ret_req   (ret_req),
    .flags_in  (flags_in),
    .cs_in     (cs_in),
    .ip_in     (ip_in),
    .sp_in     (sp_in),
    .vec_bus   (vec_bus),
    .done      (done),
    .rdata     (rdata),
    .start     (start),
    .we        (we),
    .addr      (addr),
    .wdata     (wdata),
    .dev_ack   (dev_ack),
    .busy      (busy),
    .load      (load),
    .new_flags (new_flags),
    .new_cs    (new_cs),
    .new_ip    (new_ip),
    .new_sp    (new_sp)
  );

  intr_mem_port #(.W(W), .AW(AW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .we        (we),
    .addr      (addr),
    .wdata     (wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .rdata     (rdata)
  );
endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk
  import intr_seq_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          boundary,
  input logic          ret_req,
  input logic          mask_req,
  input logic [W-1:0]  flags_in,
  input logic          dev_ack,
  input logic          busy,
  input logic          load,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [W-1:0]  mem_wdata
);
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(boundary || ret_req));

  // R3
  ack_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_ack) |-> $past(mask_req && flags_in[FL_IEN]));

  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dev_ack |=> !dev_ack);

  // R11
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);

  // R11
  mem_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R12
  port_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind intr_seq intr_seq_chk #(.W(W), .AW(AW)) u_chk (.*);

// File: tb/sim_intr_seq.sv
module sim_intr_seq;
  localparam int W = 16, VW = 8, AW = 16;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic boundary = 0, ret_req = 0, mask_req = 0, hard_req = 0, sw_req = 0, ovf_req = 0;
  logic [VW-1:0] sw_vec = 0, vec_bus = 0, dev_vec = 0;
  logic [W-1:0] flags_in = 0, cs_in = 0, ip_in = 0, sp_in = 0, mem_rdata = 0;
  logic mem_ack = 0;
  logic dev_ack, mem_req, mem_we, busy, load;
  logic [AW-1:0] mem_addr;
  logic [W-1:0] mem_wdata, new_flags, new_cs, new_ip, new_sp;

  intr_seq u0 (.*);

  int total = 0, bad = 0, port_bad = 0, ack_cycles = 0, wcount = 0;
  logic [15:0] mem [0:32767];
  logic [AW-1:0] wlog_a [0:7];
  logic [W-1:0]  wlog_d [0:7];
  logic pend = 0, h_we = 0;
  logic [AW-1:0] h_a = 0;
  logic [W-1:0]  h_d = 0;

  // device and memory responder, all on the falling edge
  always @(negedge clk) begin
    vec_bus = dev_ack ? dev_vec : '0;
    if (dev_ack) ack_cycles++;
    if (mem_req) begin
      if (pend && (mem_addr !== h_a || mem_we !== h_we || mem_wdata !== h_d)) port_bad++;
      mem_ack = (($urandom % 3) != 0);
      if (mem_ack) begin
        pend = 0;
        if (mem_we) begin
          mem[mem_addr[AW-1:1]] = mem_wdata;
          if (wcount < 8) begin wlog_a[wcount] = mem_addr; wlog_d[wcount] = mem_wdata; end
          wcount++;
        end else begin
          mem_rdata = mem[mem_addr[AW-1:1]];
        end
      end else begin
        pend = 1; h_a = mem_addr; h_we = mem_we; h_d = mem_wdata;
      end
    end else begin
      mem_ack = 0;
      pend = 0;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [8:0] want_vec(input bit sw, input logic [7:0] swv, input bit ovf,
      input bit hard, input bit mask, input logic [15:0] fl, input logic [7:0] dv);
    if (sw) return {1'b0, swv};
    if (ovf && fl[11]) return 9'd4;
    if (hard) return 9'd2;
    if (fl[8]) return 9'd1;
    if (mask && fl[9]) return {1'b0, dv};
    return 9'h100;
  endfunction

  task automatic wait_load(output bit ok);
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (load) begin ok = 1; break; end
    end
  endtask

  task automatic do_event(input bit sw, input logic [7:0] swv, input bit ovf, input bit hard,
      input bit mask, input logic [15:0] fl, input logic [15:0] cs, input logic [15:0] ip,
      input logic [15:0] sp, input logic [7:0] dv, input bit poke, input string tag);
    logic [8:0] ev;
    logic [15:0] eip, ecs;
    bit ok, maskpath;
    ev = want_vec(sw, swv, ovf, hard, mask, fl, dv);
    maskpath = !sw && !(ovf && fl[11]) && !hard && !fl[8] && mask && fl[9];
    eip = 16'($urandom);
    ecs = 16'($urandom);
    if (!ev[8]) begin
      mem[{ev[7:0], 1'b0}] = eip;
      mem[{ev[7:0], 1'b1}] = ecs;
    end
    wcount = 0; ack_cycles = 0; dev_vec = dv;
    @(negedge clk);
    sw_req = sw; sw_vec = swv; ovf_req = ovf; hard_req = hard; mask_req = mask;
    flags_in = fl; cs_in = cs; ip_in = ip; sp_in = sp; boundary = 1;
    @(negedge clk);
    boundary = 0; sw_req = 0; ovf_req = 0; hard_req = 0; mask_req = 0;
    if (ev[8]) begin
      repeat (4) @(negedge clk);
      chk($sformatf("%s no entry busy", tag), busy, 0);
      chk($sformatf("%s no entry writes", tag), wcount, 0);
      chk($sformatf("%s no entry ack", tag), ack_cycles, 0);
      return;
    end
    chk($sformatf("%s R11 busy after accept", tag), busy, 1);
    if (poke) begin
      @(negedge clk); @(negedge clk);
      boundary = 1; hard_req = 1;
      @(negedge clk);
      boundary = 0; hard_req = 0;
    end
    wait_load(ok);
    chk($sformatf("%s R11 load seen", tag), ok, 1);
    chk($sformatf("%s R11 busy low at load", tag), busy, 0);
    chk($sformatf("%s R9 new_ip", tag), new_ip, eip);
    chk($sformatf("%s R9 new_cs", tag), new_cs, ecs);
    chk($sformatf("%s R9 new_flags", tag), new_flags, fl & ~16'h0300);
    chk($sformatf("%s R9 new_sp", tag), new_sp, sp - 16'd6);
    chk($sformatf("%s R8 write count", tag), wcount, 3);
    chk($sformatf("%s R8 first push", tag), {wlog_a[0], wlog_d[0]}, {sp - 16'd2, fl});
    chk($sformatf("%s R8 second push", tag), {wlog_a[1], wlog_d[1]}, {sp - 16'd4, cs});
    chk($sformatf("%s R8 third push", tag), {wlog_a[2], wlog_d[2]}, {sp - 16'd6, ip});
    chk($sformatf("%s R3 ack cycles", tag), ack_cycles, maskpath ? 1 : 0);
    repeat (3) @(negedge clk);
    chk($sformatf("%s R11 ignored strobe busy", tag), busy, 0);
    chk($sformatf("%s R11 ignored strobe writes", tag), wcount, 3);
    wcount = 0;
    sp_in = sp - 16'd6; ret_req = 1;
    @(negedge clk);
    ret_req = 0;
    wait_load(ok);
    chk($sformatf("%s R10 load seen", tag), ok, 1);
    chk($sformatf("%s R10 ip", tag), new_ip, ip);
    chk($sformatf("%s R10 cs", tag), new_cs, cs);
    chk($sformatf("%s R10 flags", tag), new_flags, fl);
    chk($sformatf("%s R10 sp", tag), new_sp, sp);
    chk($sformatf("%s R10 no writes", tag), wcount, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ok;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32768; i++) mem[i] = 16'(i * 7);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset ack", dev_ack, 0);
    chk("R1 reset load", load, 0);
    chk("R1 reset mem_req", mem_req, 0);

    // R2: requests without a boundary
    hard_req = 1; sw_req = 1; sw_vec = 8'h33;
    repeat (5) @(negedge clk);
    chk("R2 no boundary busy", busy, 0);
    hard_req = 0; sw_req = 0;
    @(negedge clk);

    do_event(0, 0, 0, 1, 0, 16'h0000, 16'h1111, 16'h2222, 16'h4000, 0, 0, "R4 hard IEN=0");
    do_event(0, 0, 0, 0, 1, 16'h0200, 16'h1212, 16'h3434, 16'h5000, 8'h40, 0, "R3 mask IEN=1");
    do_event(0, 0, 0, 0, 1, 16'h0000, 16'h1212, 16'h3434, 16'h5000, 8'h40, 0, "R3 mask IEN=0");
    do_event(0, 0, 0, 0, 0, 16'h0100, 16'hA0A0, 16'hB0B0, 16'h6000, 0, 0, "R5 step trap");
    do_event(1, 8'h80, 0, 0, 0, 16'h0000, 16'h0101, 16'h0202, 16'h7000, 0, 0, "R7 soft vec");
    do_event(0, 0, 1, 0, 0, 16'h0800, 16'h0303, 16'h0404, 16'h7100, 0, 0, "R7 ovf set");
    do_event(0, 0, 1, 0, 0, 16'h0000, 16'h0303, 16'h0404, 16'h7100, 0, 0, "R7 ovf clear");
    do_event(1, 8'hC5, 0, 1, 1, 16'h0300, 16'h0505, 16'h0606, 16'h7200, 8'h41, 0, "R6 soft first");
    do_event(0, 0, 0, 1, 1, 16'h0300, 16'h0707, 16'h0808, 16'h7300, 8'h42, 0, "R6 hard before step");
    do_event(0, 0, 0, 0, 1, 16'h0300, 16'h0909, 16'h0A0A, 16'h7400, 8'h43, 1, "R6 step before mask");
    do_event(0, 0, 1, 1, 0, 16'h0800, 16'h0B0B, 16'h0C0C, 16'h7500, 0, 1, "R6 ovf before hard");

    // R13: return and boundary together
    mem[16'h8000 >> 1] = 16'hBEEF;
    mem[16'h8002 >> 1] = 16'hCAFE;
    mem[16'h8004 >> 1] = 16'h0246;
    wcount = 0;
    @(negedge clk);
    sp_in = 16'h8000; ret_req = 1; boundary = 1; hard_req = 1;
    @(negedge clk);
    ret_req = 0; boundary = 0; hard_req = 0;
    wait_load(ok);
    chk("R13 load seen", ok, 1);
    chk("R13 popped ip", new_ip, 16'hBEEF);
    chk("R13 popped cs", new_cs, 16'hCAFE);
    chk("R13 popped flags", new_flags, 16'h0246);
    chk("R13 no writes", wcount, 0);

    for (int n = 0; n < 40; n++) begin
      logic [15:0] fl, sp;
      fl = 16'($urandom) & 16'h0FD5;
      sp = 16'h1000 + 16'((($urandom % 28000)) * 2);
      do_event(($urandom % 5) == 0, 8'(32 + ($urandom % 224)), ($urandom % 4) == 0,
               ($urandom % 4) == 0, ($urandom % 2) == 0, fl, 16'($urandom), 16'($urandom),
               sp, 8'(32 + ($urandom % 224)), ($urandom % 2) == 0, "random");
    end

    chk("R12 port held while waiting", port_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule